// File: doc/BRIEF.md
# Dual-Tone Transceiver Register Interface

This block is the processor-side register front end of a dual-tone signalling transceiver. A host reaches it over a narrow strobed bus. The bus consists of a 4-bit data path, an active-low select, a read/write line and one register-select line. The block holds the transmit code, the received code and two control registers. Both control registers sit behind a single address. It also keeps a small status word and an interrupt request line in open-drain style. Tone synthesis, burst timing and tone-pair detection live elsewhere. They report to this block through single-cycle strobes, and it hands them back its control levels and the transmit code.

Each bus access takes one clock edge while select is low. Reads are combinational from the current register state. Any read-to-clear effect lands on the edge that closes the read. A steering bit in control register A redirects the next control write into control register B. That write then clears the steering bit again.

Top module: `tone_xcvr_regif`

## Requirements
- R1: After reset, tone enable, mode, burst and test outputs and the transmit code are 0, irq_n is 1, and a status read returns 0.
- R2: With cs_n high, no register changes on any combination of rw, rsel and wdata, and rd_oe stays 0.
- R3: A write with rsel=0 (rw=0) loads wdata into the transmit code, visible on tx_code after that edge.
- R4: A control write (rw=0, rsel=1) while the steering bit is 0 loads control A: bit 0 tone enable, bit 1 call-progress mode, bit 2 interrupt enable, bit 3 steering.
- R5: A control write while the steering bit is 1 loads control B instead (bit 0 burst mode, bit 1 test) and clears the steering bit.
- R6: A read with rsel=0 (rw=1) returns the receive code, which is loaded from rx_code on each rx_latch strobe; rd_oe is 1 during any selected read.
- R7: Status bit 2 (receive full) sets on rx_latch and clears on the edge that ends a status read (rw=1, rsel=1); a set in the same cycle wins.
- R8: Status bit 1 (transmit empty) sets on tx_pause_done while burst mode is 1, clears on a status read, and is 0 whenever burst mode was 0 at the previous edge.
- R9: Status bit 0 (interrupt) sets whenever bit 1 or bit 2 is being set and clears on a status read unless a new set arrives in that cycle.
- R10: Status bit 3 (delayed steering) sets on absent_ok and clears on pair_ok; absent_ok wins if both arrive together.
- R11: irq_n is 0 exactly while status bit 0 and control A bit 2 are both 1.
- R12: A status read returns status bits 3..0 in positions 3..0, showing their values before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus strobe clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | 0 = data registers, 1 = control/status |
| wdata | input | 4 | Write data from host |
| rdata | output | 4 | Read data to host |
| rd_oe | output | 1 | High while a selected read drives rdata |
| rx_latch | input | 1 | Strobe: receiver has a valid code |
| rx_code | input | 4 | Code from receiver |
| tx_pause_done | input | 1 | Strobe: burst pause has ended |
| absent_ok | input | 1 | Strobe: tone absence validated |
| pair_ok | input | 1 | Strobe: tone pair validated |
| tx_code | output | 4 | Code to transmitter |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode selected |
| burst_en | output | 1 | Burst mode selected |
| test_en | output | 1 | Test mode selected |
| irq_n | output | 1 | Interrupt request, 0 = asserted |

## Verification
Read data and rd_oe are combinational from the access lines, so the bench checks them one time step after driving a read and before the closing edge. Register outputs, status bits and irq_n all change at the first rising edge after the stimulus, so the bench checks them at the next falling edge. The bench model applies every set and clear using the pre-edge state, which is the same order the design uses. After reset is released, the bench waits for the two-stage reset release to finish before it applies the first vector.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW = 4;
  localparam int ST_IRQ = 0;
  localparam int ST_TXE = 1;
  localparam int ST_RXF = 2;
  localparam int ST_DST = 3;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_WR_TX   = 3'd1,
    ACC_RD_RX   = 3'd2,
    ACC_WR_CTL  = 3'd3,
    ACC_RD_STAT = 3'd4
  } acc_e;
endpackage

// File: rtl/txr_bus_decode.sv
module txr_bus_decode
  import txr_pkg::*;
(
  input  logic cs_n,
  input  logic rw,
  input  logic rsel,
  output acc_e acc
);
  always_comb begin
    acc = ACC_NONE;
    if (!cs_n) begin
      unique case ({rw, rsel})
        2'b00:   acc = ACC_WR_TX;
        2'b10:   acc = ACC_RD_RX;
        2'b01:   acc = ACC_WR_CTL;
        default: acc = ACC_RD_STAT;
      endcase
    end
  end
endmodule

// File: rtl/txr_ctrl_regs.sv
module txr_ctrl_regs #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         wr_tx,
  input  logic         wr_ctl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tx_q,
  output logic [3:0]   ctl_a,
  output logic [1:0]   ctl_b
);
  localparam int SEL_BIT = 3;

  logic [W-1:0] tx_d;
  logic [3:0]   a_d;
  logic [1:0]   b_d;
  logic         tx_ce, a_ce, b_ce;

  always_comb begin
    tx_ce = wr_tx;
    tx_d  = wdata;
    a_ce  = wr_ctl;
    b_ce  = wr_ctl && ctl_a[SEL_BIT];
    b_d   = wdata[1:0];
    if (ctl_a[SEL_BIT]) begin
      a_d          = ctl_a;
      a_d[SEL_BIT] = 1'b0;
    end else begin
      a_d = wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tx_q  <= '0;
      ctl_a <= '0;
      ctl_b <= '0;
    end else begin
      if (tx_ce) tx_q  <= tx_d;
      if (a_ce)  ctl_a <= a_d;
      if (b_ce)  ctl_b <= b_d;
    end
  end
endmodule

// File: rtl/txr_status.sv
module txr_status
  import txr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         rd_stat,
  input  logic         burst,
  input  logic         rx_latch,
  input  logic [W-1:0] rx_code,
  input  logic         pause_done,
  input  logic         absent_ok,
  input  logic         pair_ok,
  output logic [3:0]   stat,
  output logic [W-1:0] rx_q
);
  logic [3:0]   stat_d;
  logic [W-1:0] rx_d;
  logic         set_txe, set_rxf;

  always_comb begin
    set_txe = pause_done && burst;
    set_rxf = rx_latch;
    stat_d[ST_TXE] = burst && (set_txe || (stat[ST_TXE] && !rd_stat));
    stat_d[ST_RXF] = set_rxf || (stat[ST_RXF] && !rd_stat);
    stat_d[ST_IRQ] = set_txe || set_rxf || (stat[ST_IRQ] && !rd_stat);
    stat_d[ST_DST] = absent_ok || (stat[ST_DST] && !pair_ok);
    rx_d = rx_latch ? rx_code : rx_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stat <= '0;
      rx_q <= '0;
    end else begin
      stat <= stat_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/tone_xcvr_regif.sv
module tone_xcvr_regif
  import txr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          rsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe,
  input  logic          rx_latch,
  input  logic [DW-1:0] rx_code,
  input  logic          tx_pause_done,
  input  logic          absent_ok,
  input  logic          pair_ok,
  output logic [DW-1:0] tx_code,
  output logic          tone_en,
  output logic          cp_mode,
  output logic          burst_en,
  output logic          test_en,
  output logic          irq_n
);
  logic [1:0]    rst_sync;
  logic          rst_q_n;
  acc_e          acc;
  logic [3:0]    ctl_a;
  logic [1:0]    ctl_b;
  logic [3:0]    stat;
  logic [DW-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  txr_bus_decode u_dec (
    .cs_n (cs_n),
    .rw   (rw),
    .rsel (rsel),
    .acc  (acc)
  );

  txr_ctrl_regs #(.W(DW)) u_ctl (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .wr_tx   (acc == ACC_WR_TX),
    .wr_ctl  (acc == ACC_WR_CTL),
    .wdata   (wdata),
    .tx_q    (tx_code),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b)
  );

  txr_status #(.W(DW)) u_st (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .rd_stat    (acc == ACC_RD_STAT),
    .burst      (ctl_b[0]),
    .rx_latch   (rx_latch),
    .rx_code    (rx_code),
    .pause_done (tx_pause_done),
    .absent_ok  (absent_ok),
    .pair_ok    (pair_ok),
    .stat       (stat),
    .rx_q       (rx_q)
  );

  always_comb begin
    rd_oe = (acc == ACC_RD_RX) || (acc == ACC_RD_STAT);
    unique case (acc)
      ACC_RD_RX:   rdata = rx_q;
      ACC_RD_STAT: rdata = DW'(stat);
      default:     rdata = '0;
    endcase
  end

  assign tone_en  = ctl_a[0];
  assign cp_mode  = ctl_a[1];
  assign burst_en = ctl_b[0];
  assign test_en  = ctl_b[1];
  assign irq_n    = !(stat[ST_IRQ] && ctl_a[2]);
endmodule

// File: rtl/tone_xcvr_regif_chk.sv
module tone_xcvr_regif_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       cs_n,
  input logic       rw,
  input logic       rsel,
  input logic       rx_latch,
  input logic [3:0] rx_code,
  input logic [3:0] rx_q,
  input logic [3:0] tx_code,
  input logic [3:0] ctl_a,
  input logic [3:0] stat,
  input logic       burst_en,
  input logic       tx_pause_done,
  input logic       absent_ok,
  input logic       pair_ok
);
  // R2
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cs_n |=> $stable(tx_code));
  // R5
  steer_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cs_n && !rw && rsel && ctl_a[3]) |=> !ctl_a[3]);
  // R6
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_latch |=> (rx_q == $past(rx_code)));
  // R7
  rxfull_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_latch |=> stat[2]);
  // R8
  txe_burst_off_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !burst_en |=> !stat[1]);
  // R9
  irq_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cs_n && rw && rsel && !rx_latch && !(tx_pause_done && burst_en)) |=> !stat[0]);
  // R10
  dst_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pair_ok && !absent_ok) |=> !stat[3]);
endmodule

bind tone_xcvr_regif tone_xcvr_regif_chk u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .cs_n          (cs_n),
  .rw            (rw),
  .rsel          (rsel),
  .rx_latch      (rx_latch),
  .rx_code       (rx_code),
  .rx_q          (rx_q),
  .tx_code       (tx_code),
  .ctl_a         (ctl_a),
  .stat          (stat),
  .burst_en      (burst_en),
  .tx_pause_done (tx_pause_done),
  .absent_ok     (absent_ok),
  .pair_ok       (pair_ok)
);

// File: tb/tb_tone_xcvr_regif.sv
module tb_tone_xcvr_regif;
  logic clk = 1'b0;
  logic rst_n, cs_n, rw, rsel, rx_latch, tx_pause_done, absent_ok, pair_ok;
  logic [3:0] wdata, rx_code, rdata, tx_code;
  logic rd_oe, tone_en, cp_mode, burst_en, test_en, irq_n;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  logic [3:0] m_a, m_tx, m_rx, m_st;
  logic [1:0] m_b;

  always #4 clk = ~clk;

  tone_xcvr_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rsel(rsel),
    .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe), .rx_latch(rx_latch),
    .rx_code(rx_code), .tx_pause_done(tx_pause_done), .absent_ok(absent_ok),
    .pair_ok(pair_ok), .tx_code(tx_code), .tone_en(tone_en), .cp_mode(cp_mode),
    .burst_en(burst_en), .test_en(test_en), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, "tx_code", int'(tx_code), int'(m_tx));
    chk(tag, "tone_en", int'(tone_en), int'(m_a[0]));
    chk(tag, "cp_mode", int'(cp_mode), int'(m_a[1]));
    chk(tag, "burst_en", int'(burst_en), int'(m_b[0]));
    chk(tag, "test_en", int'(test_en), int'(m_b[1]));
    chk(tag, "irq_n", int'(irq_n), int'(!(m_st[0] && m_a[2])));
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input string tag, input logic c, input logic r, input logic s,
                     input logic [3:0] wd, input logic rxl, input logic [3:0] rxc,
                     input logic pd, input logic ab, input logic pv);
    logic rdst, bo;
    cs_n = c; rw = r; rsel = s; wdata = wd; rx_latch = rxl; rx_code = rxc;
    tx_pause_done = pd; absent_ok = ab; pair_ok = pv;
    #1;
    chk(tag, "rd_oe", int'(rd_oe), int'(!c && r));
    if (!c && r) chk(tag, "rdata", int'(rdata), int'(s ? m_st : m_rx));
    @(posedge clk);
    rdst = !c && r && s;
    bo = m_b[0];
    if (!c && !r && !s) m_tx = wd;
    if (!c && !r && s) begin
      if (m_a[3]) begin m_b = wd[1:0]; m_a[3] = 1'b0; end
      else m_a = wd;
    end
    m_st[1] = bo && ((pd && bo) || (m_st[1] && !rdst));
    m_st[2] = rxl || (m_st[2] && !rdst);
    m_st[0] = (pd && bo) || rxl || (m_st[0] && !rdst);
    m_st[3] = ab || (m_st[3] && !pv);
    if (rxl) m_rx = rxc;
    @(negedge clk);
    cs_n = 1'b1; rx_latch = 0; tx_pause_done = 0; absent_ok = 0; pair_ok = 0;
    chk_outs(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1, 0, 0, 4'h0, 0, 4'h0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    m_a = 0; m_b = 0; m_tx = 0; m_rx = 0; m_st = 0;
    rst_n = 0; cs_n = 1; rw = 0; rsel = 0; wdata = 0; rx_latch = 0; rx_code = 0;
    tx_pause_done = 0; absent_ok = 0; pair_ok = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_outs("R1");
    cyc("R1", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);

    // R3 every transmit code
    for (int v = 0; v < 16; v++) cyc("R3", 0, 0, 0, 4'(v), 0, 4'h0, 0, 0, 0);

    // R4 / R5 control A sweep, with B written when steering is set
    for (int v = 0; v < 16; v++) begin
      cyc("R4", 0, 0, 1, 4'(v), 0, 4'h0, 0, 0, 0);
      if (v >= 8) cyc("R5", 0, 0, 1, 4'(15 - v), 0, 4'h0, 0, 0, 0);
    end

    // R2 deselected accesses of every kind leave state alone
    for (int k = 0; k < 16; k++)
      cyc("R2", 1, k[0], k[1], 4'(k * 5), 0, 4'h0, 0, 0, 0);

    // R6 / R7 / R12 / R9 receive sweep
    cyc("R4", 0, 0, 1, 4'h4, 0, 4'h0, 0, 0, 0);
    for (int v = 0; v < 16; v++) begin
      cyc("R6", 0, 0, 0, 4'h0, 1, 4'(v ^ 4'h9), 0, 0, 0);
      cyc("R6", 0, 1, 0, 4'h0, 0, 4'h0, 0, 0, 0);
      cyc("R12", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
      cyc("R7", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    end
    // R7 set wins over clear in the same cycle
    cyc("R7", 0, 1, 1, 4'h0, 1, 4'h3, 0, 0, 0);
    cyc("R9", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);

    // R8 pause done without burst is ignored
    cyc("R8", 1, 0, 0, 4'h0, 0, 4'h0, 1, 0, 0);
    cyc("R8", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    // R8 enable burst: steer to B then write burst
    cyc("R5", 0, 0, 1, 4'hC, 0, 4'h0, 0, 0, 0);
    cyc("R5", 0, 0, 1, 4'h1, 0, 4'h0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 4'h0, 0, 4'h0, 1, 0, 0);
    cyc("R11", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    cyc("R8", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 4'h0, 0, 4'h0, 1, 0, 0);
    // R8 turning burst off clears transmit-empty without a read
    cyc("R5", 0, 0, 1, 4'hC, 0, 4'h0, 0, 0, 0);
    cyc("R5", 0, 0, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    idle("R8");
    cyc("R8", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);

    // R11 interrupt gating by enable bit
    cyc("R11", 0, 0, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    cyc("R11", 1, 0, 0, 4'h0, 1, 4'h5, 0, 0, 0);
    cyc("R11", 0, 0, 1, 4'h4, 0, 4'h0, 0, 0, 0);
    cyc("R11", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);

    // R10 delayed steering set/clear/priority
    cyc("R10", 1, 0, 0, 4'h0, 0, 4'h0, 0, 1, 0);
    cyc("R10", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);
    cyc("R10", 1, 0, 0, 4'h0, 0, 4'h0, 0, 1, 1);
    cyc("R10", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 1);
    cyc("R10", 0, 1, 1, 4'h0, 0, 4'h0, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule